// File: doc/BRIEF.md
# Perturb-and-Observe Power Point Tracker

This block steers a photovoltaic source toward its maximum power point by hill climbing on a command word, normally the duty cycle of the power converter it feeds. After each command change it waits a programmable settling interval. It then averages the product of sampled voltage and current over a programmable number of samples. It compares that average with the one from the previous round and decides which way to move next. A rise in power keeps the direction. A fall or a tie reverses it. The step starts at its maximum and halves on each reversal, so the command homes in and then jitters only by a small amount around the peak. A run of consecutive gains doubles the step again, which lets the tracker follow a peak that has moved.

The controller is a five-state machine. INIT loads the settle timer and clears the averager, then goes to SETTLE. SETTLE counts the settling interval down and goes to ACCUM when it expires. ACCUM gathers valid samples and goes to DECIDE once the required number has arrived. DECIDE compares powers and updates the direction, the step and the gain streak, then goes to APPLY. APPLY moves and clamps the command, pulses `step_pulse`, reloads the timer, clears the averager and returns to SETTLE. All settings are sampled live. They are meant to be changed only while reset is held.

Top module: `mpp_hill_climb`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cmd` equals `cmd_init`, `step_size` equals `step_max`, `dir_up` is 1 and `step_pulse` is 0.
- R2: After reset and after every command update, the block ignores valid samples for at least `settle_cycles` clock cycles. Samples in that window have no effect on any later decision.
- R3: The measured power is the sum of `smp_volt*smp_curr` over the first 2^`avg_shift` samples with `smp_valid`=1 after the settle window, shifted right by `avg_shift` (floor). Cycles with `smp_valid`=0 contribute nothing.
- R4: The first measurement after reset only becomes the reference. Direction and step stay as they were, and the command is then moved in the current direction.
- R5: When the new power is strictly greater than the reference, the direction is kept and a gain streak counts up. When the streak reaches `grow_count` (at least 1), the step becomes min(2*step, `step_max`) and the streak restarts at zero.
- R6: When the new power is equal to or lower than the reference, the direction flips, the step becomes max(floor(step/2), `step_min`) and the streak restarts at zero.
- R7: A move adds the step when `dir_up`=1 and subtracts it when `dir_up`=0. If the result would reach or pass `cmd_max` (moving up) or `cmd_min` (moving down), `cmd` takes that limit, the direction flips, the step is unchanged and the streak restarts.
- R8: `step_pulse` is high for exactly one cycle per measurement, in the first cycle in which `cmd` shows its new value. `cmd` holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Voltage and current sample strobe |
| smp_volt | input | VW (12) | Sampled source voltage |
| smp_curr | input | IW (12) | Sampled source current |
| settle_cycles | input | SW (16) | Settling interval in clock cycles |
| avg_shift | input | AW (2) | log2 of the number of samples averaged |
| step_min | input | CW (12) | Smallest step size |
| step_max | input | CW (12) | Largest step size, also the step after reset |
| cmd_min | input | CW (12) | Lower command limit |
| cmd_max | input | CW (12) | Upper command limit |
| cmd_init | input | CW (12) | Command value after reset |
| grow_count | input | GW (4) | Consecutive gains needed to double the step |
| cmd | output | CW (12) | Control command (duty cycle) |
| dir_up | output | 1 | Current direction, 1 means increasing |
| step_size | output | CW (12) | Current step size |
| step_pulse | output | 1 | One-cycle marker of a command update |

## Verification
The assertions take the following for granted about the inputs. The settings hold steady outside reset. `step_min` is at least 1 and no larger than `step_max`. `cmd_min` lies below `cmd_max`, `cmd_init` lies between them, and `grow_count` is at least 1. The step and command range checks depend on these. The bench changes settings only while reset is asserted and draws random values inside these bounds. Its samples come from a concave power curve with a peak drawn at random and a little random noise added. Each run also sends oversized samples during the settle window, which must leave no trace on the outcome.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_ACCUM  = 3'd2,
        ST_DECIDE = 3'd3,
        ST_APPLY  = 3'd4
    } track_state_t;

endpackage

// File: rtl/mpp_settle_timer.sv
module mpp_settle_timer #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [SW-1:0] span,
    output logic          expired
);

    logic [SW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= span;
        end else if (run && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !load && expired) |=> expired); // R2

    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (remain == $past(span))); // R2

endmodule

// File: rtl/mpp_power_avg.sv
module mpp_power_avg #(
    parameter int VW = 12,
    parameter int IW = 12,
    parameter int AW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic [VW-1:0]    smp_volt,
    input  logic [IW-1:0]    smp_curr,
    input  logic [AW-1:0]    shift,
    output logic             done,
    output logic [VW+IW-1:0] avg
);

    localparam int PW    = VW + IW;
    localparam int MAXSH = (1 << AW) - 1;
    localparam int ACCW  = PW + MAXSH;
    localparam int CNTW  = MAXSH + 2;

    logic [ACCW-1:0] acc;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] need;
    logic [PW-1:0]   prod;
    logic            take;

    assign need = CNTW'(1) << shift;
    assign prod = PW'(smp_volt) * PW'(smp_curr);
    assign take = enable && smp_valid && !done;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc  <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (take) begin
            acc <= acc + ACCW'(prod);
            cnt <= cnt + 1'b1;
            if ((cnt + 1'b1) == need) begin
                done <= 1'b1;
            end
        end
    end

    assign avg = PW'(acc >> shift);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= need); // R3

    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> (done && $stable(acc))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!enable && !clear) |=> $stable(acc)); // R2

endmodule

// File: rtl/mpp_step_adapt.sv
module mpp_step_adapt #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] step_now,
    input  logic [CW-1:0] step_min,
    input  logic [CW-1:0] step_max,
    input  logic          grow,
    input  logic          shrink,
    output logic [CW-1:0] step_next
);

    logic [CW:0]   doubled;
    logic [CW-1:0] halved;

    assign doubled = {step_now, 1'b0};
    assign halved  = step_now >> 1;

    always_comb begin
        step_next = step_now;
        if (shrink) begin
            step_next = (halved < step_min) ? step_min : halved;
        end else if (grow) begin
            step_next = (doubled > {1'b0, step_max}) ? step_max : doubled[CW-1:0];
        end
    end

    always_comb begin
        AST_ONE_ACTION: assert (!(grow && shrink)); // R5
    end

endmodule

// File: rtl/mpp_cmd_limit.sv
module mpp_cmd_limit #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] cmd_now,
    input  logic [CW-1:0] step,
    input  logic          up,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic [CW-1:0] cmd_next,
    output logic          at_limit
);

    logic [CW:0] raised;
    logic [CW:0] floor_gap;

    assign raised    = {1'b0, cmd_now} + {1'b0, step};
    assign floor_gap = {1'b0, lo} + {1'b0, step};

    always_comb begin
        if (up) begin
            if (raised >= {1'b0, hi}) begin
                cmd_next = hi;
                at_limit = 1'b1;
            end else begin
                cmd_next = raised[CW-1:0];
                at_limit = 1'b0;
            end
        end else begin
            if ({1'b0, cmd_now} <= floor_gap) begin
                cmd_next = lo;
                at_limit = 1'b1;
            end else begin
                cmd_next = cmd_now - step;
                at_limit = 1'b0;
            end
        end
    end

endmodule

// File: rtl/mpp_hill_climb.sv
module mpp_hill_climb
    import mpp_pkg::*;
#(
    parameter int VW = 12,
    parameter int IW = 12,
    parameter int CW = 12,
    parameter int SW = 16,
    parameter int AW = 2,
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [VW-1:0] smp_volt,
    input  logic [IW-1:0] smp_curr,
    input  logic [SW-1:0] settle_cycles,
    input  logic [AW-1:0] avg_shift,
    input  logic [CW-1:0] step_min,
    input  logic [CW-1:0] step_max,
    input  logic [CW-1:0] cmd_min,
    input  logic [CW-1:0] cmd_max,
    input  logic [CW-1:0] cmd_init,
    input  logic [GW-1:0] grow_count,
    output logic [CW-1:0] cmd,
    output logic          dir_up,
    output logic [CW-1:0] step_size,
    output logic          step_pulse
);

    localparam int PW = VW + IW;

    track_state_t state, state_nx;

    logic          tmr_load, tmr_run, tmr_expired;
    logic          avg_clear, avg_enable, avg_done;
    logic [PW-1:0] avg_pwr;
    logic [PW-1:0] ref_pwr;
    logic          have_ref;
    logic [GW-1:0] streak;
    logic [GW-1:0] streak_inc;
    logic          better;
    logic          grow_req, shrink_req;
    logic [CW-1:0] step_nx;
    logic [CW-1:0] cmd_nx;
    logic          hit_limit;

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    mpp_settle_timer #(.SW(SW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .run     (tmr_run),
        .span    (settle_cycles),
        .expired (tmr_expired)
    );

    mpp_power_avg #(.VW(VW), .IW(IW), .AW(AW)) u_avg (
        .clk       (clk),
        .rst       (rst),
        .clear     (avg_clear),
        .enable    (avg_enable),
        .smp_valid (smp_valid),
        .smp_volt  (smp_volt),
        .smp_curr  (smp_curr),
        .shift     (avg_shift),
        .done      (avg_done),
        .avg       (avg_pwr)
    );

    mpp_step_adapt #(.CW(CW)) u_step (
        .step_now  (step_size),
        .step_min  (step_min),
        .step_max  (step_max),
        .grow      (grow_req),
        .shrink    (shrink_req),
        .step_next (step_nx)
    );

    mpp_cmd_limit #(.CW(CW)) u_limit (
        .cmd_now  (cmd),
        .step     (step_size),
        .up       (dir_up),
        .lo       (cmd_min),
        .hi       (cmd_max),
        .cmd_next (cmd_nx),
        .at_limit (hit_limit)
    );

    // ---------------------------------------------------------------
    // Control decode
    // ---------------------------------------------------------------
    assign better     = (avg_pwr > ref_pwr);
    assign streak_inc = streak + 1'b1;

    always_comb begin
        tmr_load   = (state == ST_INIT) || (state == ST_APPLY);
        tmr_run    = (state == ST_SETTLE);
        avg_clear  = (state == ST_INIT) || (state == ST_APPLY);
        avg_enable = (state == ST_ACCUM);
        grow_req   = (state == ST_DECIDE) && have_ref && better && (streak_inc >= grow_count);
        shrink_req = (state == ST_DECIDE) && have_ref && !better;
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:   state_nx = ST_SETTLE;
            ST_SETTLE: if (tmr_expired) state_nx = ST_ACCUM;
            ST_ACCUM:  if (avg_done) state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = ST_APPLY;
            ST_APPLY:  state_nx = ST_SETTLE;
            default:   state_nx = ST_INIT;
        endcase
    end

    // ---------------------------------------------------------------
    // Outputs and tracking state
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd        <= cmd_init;
            dir_up     <= 1'b1;
            step_size  <= step_max;
            step_pulse <= 1'b0;
            ref_pwr    <= '0;
            have_ref   <= 1'b0;
            streak     <= '0;
        end else begin
            step_pulse <= 1'b0;
            unique case (state)
                ST_DECIDE: begin
                    if (have_ref) begin
                        step_size <= step_nx;
                        if (better) begin
                            streak <= grow_req ? '0 : streak_inc;
                        end else begin
                            dir_up <= !dir_up;
                            streak <= '0;
                        end
                    end
                    ref_pwr  <= avg_pwr;
                    have_ref <= 1'b1;
                end
                ST_APPLY: begin
                    cmd        <= cmd_nx;
                    step_pulse <= 1'b1;
                    if (hit_limit) begin
                        dir_up <= !dir_up;
                        streak <= '0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse); // R8

    AST_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !step_pulse |-> $stable(cmd)); // R8

    AST_CMD_RANGE: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> ((cmd >= cmd_min) && (cmd <= cmd_max))); // R7

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (step_size >= step_min) && (step_size <= step_max)); // R6

    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DECIDE) && !have_ref) |=> ($stable(dir_up) && $stable(step_size))); // R4

    AST_SETTLE_BEFORE_ACCUM: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ACCUM) && !$past(state == ST_ACCUM)) |-> $past(state == ST_SETTLE)); // R2

endmodule

// File: tb/mpp_hill_climb_test.sv
module mpp_hill_climb_test;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [11:0]   smp_volt = '0;
    logic [11:0]   smp_curr = '0;
    logic [15:0]   settle_cycles = 16'd10;
    logic [1:0]    avg_shift = 2'd2;
    logic [CW-1:0] step_min = 12'd4;
    logic [CW-1:0] step_max = 12'd256;
    logic [CW-1:0] cmd_min = 12'd100;
    logic [CW-1:0] cmd_max = 12'd3900;
    logic [CW-1:0] cmd_init = 12'd2000;
    logic [3:0]    grow_count = 4'd3;
    logic [CW-1:0] cmd;
    logic          dir_up;
    logic [CW-1:0] step_size;
    logic          step_pulse;

    mpp_hill_climb uut (
        .clk           (clk),
        .rst           (rst),
        .smp_valid     (smp_valid),
        .smp_volt      (smp_volt),
        .smp_curr      (smp_curr),
        .settle_cycles (settle_cycles),
        .avg_shift     (avg_shift),
        .step_min      (step_min),
        .step_max      (step_max),
        .cmd_min       (cmd_min),
        .cmd_max       (cmd_max),
        .cmd_init      (cmd_init),
        .grow_count    (grow_count),
        .cmd           (cmd),
        .dir_up        (dir_up),
        .step_size     (step_size),
        .step_pulse    (step_pulse)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 0;

    // model state
    int     m_cmd, m_step, m_streak;
    bit     m_dir, m_have;
    longint m_ref;
    // power curve
    int peak, slope;
    bit flat, noisy;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int curr_of(int c);
        int d, r;
        if (flat) return 1000;
        d = (c > peak) ? c - peak : peak - c;
        r = 3000 - (d * slope) / 4;
        return (r < 0) ? 0 : r;
    endfunction

    function automatic int volt_of(int c);
        return flat ? 500 : 1000 + c / 16;
    endfunction

    // model of the decision and move, from R4..R7
    task automatic model_step(input longint p);
        if (m_have) begin
            if (p > m_ref) begin                                   // R5
                m_streak++;
                if (m_streak >= int'(grow_count)) begin
                    m_step   = (2 * m_step > int'(step_max)) ? int'(step_max) : 2 * m_step;
                    m_streak = 0;
                end
            end else begin                                        // R6
                m_dir    = !m_dir;
                m_step   = (m_step / 2 < int'(step_min)) ? int'(step_min) : m_step / 2;
                m_streak = 0;
            end
        end
        m_ref  = p;
        m_have = 1;
        if (m_dir) begin                                          // R7
            if (m_cmd + m_step >= int'(cmd_max)) begin
                m_cmd = cmd_max; m_dir = 0; m_streak = 0;
            end else m_cmd = m_cmd + m_step;
        end else begin
            if (m_cmd <= int'(cmd_min) + m_step) begin
                m_cmd = cmd_min; m_dir = 1; m_streak = 0;
            end else m_cmd = m_cmd - m_step;
        end
    endtask

    // called at the negedge of a reference point (reset release or pulse)
    task automatic one_round(input bit first);
        int     nsmp, w, v, i;
        longint sum, p;
        bit     seen;
        nsmp = 1 << avg_shift;
        for (int t = 1; t <= int'(settle_cycles) + 4; t++) begin
            if (t <= int'(settle_cycles) / 2) begin              // R2 oversized samples during settling
                smp_valid = 1; smp_volt = 12'hFFF; smp_curr = 12'hFFF;
            end else begin
                smp_valid = 0;
            end
            @(negedge clk);
            if (t == 1 && !first) begin
                check("R8 pulse single", step_pulse, 0);
                check("R8 cmd held", cmd, m_cmd);
            end
        end
        sum = 0;
        for (int k = 0; k < nsmp; k++) begin
            v = volt_of(m_cmd) + (noisy ? int'($urandom % 8) : 0);
            i = curr_of(m_cmd) + (noisy ? int'($urandom % 8) : 0);
            sum += longint'(v) * longint'(i);
            smp_valid = 1; smp_volt = v[11:0]; smp_curr = i[11:0];
            @(negedge clk);
            smp_valid = 0;                                        // R3 gap cycle with valid low
            smp_volt = 12'hFFF; smp_curr = 12'hFFF;
            if (k[0]) @(negedge clk);
        end
        smp_valid = 0;
        p = sum >> avg_shift;                                     // R3
        if (first) begin
            check("R4 first keeps dir", dir_up, 1);
            check("R4 first keeps step", step_size, step_max);
        end
        model_step(p);
        seen = 0;
        w = 0;
        while (!seen && w < 40) begin
            if (step_pulse) seen = 1;
            else begin
                @(negedge clk);
                w++;
            end
        end
        check("R8 pulse seen", seen, 1);
        check("R7 cmd after move", cmd, m_cmd);
        check("R6 dir after decision", dir_up, m_dir);
        check("R5 step after decision", step_size, m_step);
    endtask

    task automatic scenario(input int st, input int sh, input int smin, input int smax,
                            input int cmn, input int cmx, input int cin, input int gr,
                            input int pk, input int sl, input bit fl, input bit nz, input int rounds);
        rst = 1;
        smp_valid = 0;
        settle_cycles = st[15:0]; avg_shift = sh[1:0];
        step_min = smin[11:0]; step_max = smax[11:0];
        cmd_min = cmn[11:0]; cmd_max = cmx[11:0]; cmd_init = cin[11:0];
        grow_count = gr[3:0];
        peak = pk; slope = sl; flat = fl; noisy = nz;
        repeat (5) @(negedge clk);
        check("R1 reset cmd", cmd, cin);
        check("R1 reset step", step_size, smax);
        check("R1 reset dir", dir_up, 1);
        check("R1 reset pulse", step_pulse, 0);
        rst = 0;
        @(negedge clk);
        check("R1 first cycle cmd", cmd, cin);
        m_cmd = cin; m_step = smax; m_dir = 1; m_have = 0; m_streak = 0; m_ref = 0;
        for (int r = 0; r < rounds; r++) begin
            one_round(r == 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        // directed: peak mid-range
        scenario(10, 2, 4, 256, 100, 3900, 2000, 3, 1500, 4, 0, 1, 40);
        // directed: rising everywhere, upper clamp (R7)
        scenario(6, 1, 2, 512, 100, 3900, 3000, 2, 5000, 2, 0, 0, 25);
        // directed: falling everywhere, lower clamp (R7)
        scenario(6, 1, 2, 512, 200, 3900, 600, 2, -900, 2, 0, 0, 25);
        // directed: flat power, ties reverse and shrink to the minimum (R6)
        scenario(3, 0, 3, 200, 100, 3900, 2000, 3, 0, 0, 1, 0, 20);
        // directed: no settle, single sample, immediate growth (R5)
        scenario(0, 0, 1, 64, 50, 4000, 200, 1, 3500, 1, 0, 1, 40);
        // directed: eight-sample average, longer settle (R3)
        scenario(15, 3, 8, 300, 100, 3900, 1000, 4, 2800, 6, 0, 1, 25);
        // constrained random
        for (int s = 0; s < 4; s++) begin
            int smin, smax, cmn, cmx, cin;
            smin = 1 + int'($urandom % 8);
            smax = smin + int'($urandom % 400);
            cmn  = int'($urandom % 500);
            cmx  = 3000 + int'($urandom % 1000);
            cin  = cmn + int'($urandom % (cmx - cmn + 1));
            scenario(int'($urandom % 20), int'($urandom % 4), smin, smax, cmn, cmx, cin,
                     1 + int'($urandom % 5), int'($urandom % 4096), 1 + int'($urandom % 8),
                     0, 1, 30);
        end
        summary();
    end

endmodule